// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block turns a digitized supply-good level into a clean system reset. It also watches the chip-select line of a host serial link and fires reset when that line stops toggling. The reset is asserted at once whenever supply-good is low. After the supply comes back, reset is kept asserted until supply-good has been high for a fixed hold interval with no break. The hold count uses only synchronized supply state, so an early pulse of supply-good cannot shorten it.

The watchdog runs only while reset is released. It is enabled by `wdt_en` and by a two-bit timeout select. Only a falling edge of chip-select restarts it. If chip-select stays at one level, high or low, longer than the chosen timeout, the watchdog forces a reset for one hold interval and then starts counting again from zero. Every timeout is given in milliseconds and converted to clock cycles from a clock-frequency parameter, so a simulation can use short intervals. A parameter sets the reset polarity.

Top module: `sup_rst_gen`

## Requirements
- R1: While `pwr_ok` is low, the reset output is asserted, with no clock edge needed.
- R2: When `pwr_ok` rises between two clock edges, reset is released after rising edge number HOLD_CYC+2 that follows the rise. This is two synchronizer stages plus the hold count, with HOLD_CYC = (CLK_HZ/1000)·HOLD_MS.
- R3: If `pwr_ok` drops at any point during the hold interval, the full hold count starts again once `pwr_ok` returns.
- R4: With the watchdog active, a falling edge of `cs_n` applied between two clock edges restarts the count. If `cs_n` then produces no further falling edge, reset asserts after rising edge number L+3 that follows the falling edge, where L is the selected timeout in cycles.
- R5: If `cs_n` stays high after reset is released, reset asserts after rising edge number L that follows the release.
- R6: A rising edge of `cs_n` does not restart the count. Falling edges spaced fewer than L cycles apart keep reset released.
- R7: `wdt_sel` encoding: 2'b00 selects WDT_LONG_MS, 2'b01 selects WDT_MID_MS, 2'b10 selects WDT_SHORT_MS, and 2'b11 disables the watchdog. `wdt_en` low also disables it. While the watchdog is disabled its count is held at zero.
- R8: A watchdog timeout holds reset for exactly HOLD_CYC cycles. The watchdog then counts again from zero, so the next timeout with `cs_n` static comes L cycles after the release.
- R9: With RST_ACT_HIGH=1 the output is high during reset. With RST_ACT_HIGH=0 it is low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, frequency given by CLK_HZ |
| pwr_ok | input | 1 | Supply-good comparator level, high when supply is above the trip point; low also clears the block |
| cs_n | input | 1 | Chip-select line observed by the watchdog, asynchronous |
| wdt_en | input | 1 | Watchdog enable, high to enable |
| wdt_sel | input | 2 | Watchdog timeout select, encoded as in R7 |
| rst_out | output | 1 | System reset, polarity set by RST_ACT_HIGH |

## Verification
On every cycle, the assertions check three rules. Reset must be asserted whenever supply-good is low. Reset may be released only after at least a full hold interval of asserted reset with good supply. A reset rising while supply is good must be caused by a watchdog timeout. The assertions also check that a chip-select falling edge and a disabled setting both clear the watchdog count. Only the directed scenarios can show the exact release and timeout cycles for each select value, the restart of the hold count after a supply dip, the fact that a rising edge of chip-select does not restart the watchdog, and the output polarity of both variants.

// File: rtl/sup_rst_pkg.sv
`timescale 1ns/1ps
package sup_rst_pkg;

  typedef enum logic [1:0] {
    WSEL_LONG  = 2'b00,
    WSEL_MID   = 2'b01,
    WSEL_SHORT = 2'b10,
    WSEL_OFF   = 2'b11
  } wdt_sel_e;

  // Converts a duration in milliseconds into clock cycles.
  function automatic int unsigned ms_cycles(input int unsigned clk_hz,
                                            input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

  // Timeout in cycles for a select code; zero means the watchdog is off.
  function automatic int unsigned sel_cycles(input wdt_sel_e sel,
                                             input int unsigned c_long,
                                             input int unsigned c_mid,
                                             input int unsigned c_short);
    case (sel)
      WSEL_LONG:  return c_long;
      WSEL_MID:   return c_mid;
      WSEL_SHORT: return c_short;
      default:    return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_sync2.sv
`timescale 1ns/1ps
// Two-stage synchronizer with an asynchronous clear to a chosen value.
module sup_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sup_hold_timer.sv
`timescale 1ns/1ps
// Keeps reset asserted until supply has been good for HOLD_CYC cycles
// without a break, or for HOLD_CYC cycles after a watchdog restart.
module sup_hold_timer #(
  parameter int unsigned HOLD_CYC = 16,
  parameter int unsigned CW       = 5
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pg_s,
  input  logic restart,
  output logic hold_q
);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (!pg_s || restart) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (cnt_q == HOLD_LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_wdt.sv
`timescale 1ns/1ps
// Activity watchdog: restarted by a kick pulse, bites after the selected
// number of cycles without one.
module sup_wdt #(
  parameter int unsigned C_LONG  = 40,
  parameter int unsigned C_MID   = 30,
  parameter int unsigned C_SHORT = 20,
  parameter int unsigned CW      = 6
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en,
  input  logic [1:0]    sel,
  input  logic          inhibit,
  input  logic          kick,
  output logic          bite,
  output logic [CW-1:0] cnt_q
);
  import sup_rst_pkg::*;

  wdt_sel_e      sel_e;
  logic [CW-1:0] last_cnt;
  logic          active;

  always_comb begin
    sel_e    = wdt_sel_e'(sel);
    last_cnt = CW'(sel_cycles(sel_e, C_LONG, C_MID, C_SHORT) - 1);
    active   = en && (sel_e != WSEL_OFF) && !inhibit;
    bite     = active && !kick && (cnt_q == last_cnt);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (!active || kick || bite) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sup_rst_gen.sv
`timescale 1ns/1ps
module sup_rst_gen #(
  parameter int unsigned CLK_HZ       = 1_000_000,
  parameter int unsigned HOLD_MS      = 200,
  parameter int unsigned WDT_LONG_MS  = 1400,
  parameter int unsigned WDT_MID_MS   = 600,
  parameter int unsigned WDT_SHORT_MS = 200,
  parameter bit          RST_ACT_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       pwr_ok,
  input  logic       cs_n,
  input  logic       wdt_en,
  input  logic [1:0] wdt_sel,
  output logic       rst_out
);
  import sup_rst_pkg::*;

  localparam int unsigned HOLD_CYC  = ms_cycles(CLK_HZ, HOLD_MS);
  localparam int unsigned C_LONG    = ms_cycles(CLK_HZ, WDT_LONG_MS);
  localparam int unsigned C_MID     = ms_cycles(CLK_HZ, WDT_MID_MS);
  localparam int unsigned C_SHORT   = ms_cycles(CLK_HZ, WDT_SHORT_MS);
  localparam int unsigned MAX_CYC   = max3(HOLD_CYC, C_LONG, max3(C_MID, C_SHORT, 1));
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  // Named internal events, also observed by the bound checker.
  logic          pg_s;
  logic          cs_s;
  logic          cs_prev_q;
  logic          cs_fall;
  logic          hold_q;
  logic          wdt_bite;
  logic [CW-1:0] wdt_cnt;
  logic          rst_act;

  // Supply-good: cleared at once by its own low level, released in sync.
  sup_sync2 #(.RST_VAL(1'b0)) u_pg_sync (
    .clk    (clk),
    .arst_n (pwr_ok),
    .d      (1'b1),
    .q      (pg_s)
  );

  sup_sync2 #(.RST_VAL(1'b1)) u_cs_sync (
    .clk    (clk),
    .arst_n (pwr_ok),
    .d      (cs_n),
    .q      (cs_s)
  );

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) cs_prev_q <= 1'b1;
    else         cs_prev_q <= cs_s;
  end

  assign cs_fall = cs_prev_q & ~cs_s;

  sup_hold_timer #(.HOLD_CYC(HOLD_CYC), .CW(CW)) u_hold (
    .clk     (clk),
    .arst_n  (pwr_ok),
    .pg_s    (pg_s),
    .restart (wdt_bite),
    .hold_q  (hold_q)
  );

  sup_wdt #(.C_LONG(C_LONG), .C_MID(C_MID), .C_SHORT(C_SHORT), .CW(CW)) u_wdt (
    .clk     (clk),
    .arst_n  (pwr_ok),
    .en      (wdt_en),
    .sel     (wdt_sel),
    .inhibit (hold_q),
    .kick    (cs_fall),
    .bite    (wdt_bite),
    .cnt_q   (wdt_cnt)
  );

  assign rst_act = hold_q | ~pwr_ok;

  generate
    if (RST_ACT_HIGH) begin : g_act_high
      assign rst_out = rst_act;
    end else begin : g_act_low
      assign rst_out = ~rst_act;
    end
  endgenerate
endmodule

// File: rtl/sup_rst_chk.sv
`timescale 1ns/1ps
module sup_rst_chk #(
  parameter int unsigned HOLD_CYC = 16,
  parameter int unsigned CW       = 5,
  parameter bit          ACT_HIGH = 1'b0
) (
  input logic          clk,
  input logic          pwr_ok,
  input logic          rst_out,
  input logic          wdt_en,
  input logic [1:0]    wdt_sel,
  input logic          wdt_bite,
  input logic          cs_fall,
  input logic [CW-1:0] wdt_cnt
);
  logic          rst_seen;
  logic [CW:0]   asserted_cnt;

  assign rst_seen = ACT_HIGH ? rst_out : ~rst_out;

  // Cycles of asserted reset under good supply, saturating at HOLD_CYC.
  always_ff @(posedge clk) begin
    if (!rst_seen || !pwr_ok) asserted_cnt <= '0;
    else if (asserted_cnt < (CW+1)'(HOLD_CYC)) asserted_cnt <= asserted_cnt + 1'b1;
  end

  p_pg_low_rst_r1: assert property (@(posedge clk) !pwr_ok |-> rst_seen);

  p_hold_len_r2: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(rst_seen) |-> (asserted_cnt >= (CW+1)'(HOLD_CYC)));

  p_bite_rst_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
    wdt_bite |=> rst_seen);

  p_rise_cause_r8: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(rst_seen) |-> $past(wdt_bite));

  p_kick_clear_r6: assert property (@(posedge clk) disable iff (!pwr_ok)
    cs_fall |=> (wdt_cnt == '0));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!pwr_ok)
    (!wdt_en || wdt_sel == 2'b11) |=> (wdt_cnt == '0));
endmodule

bind sup_rst_gen sup_rst_chk #(
  .HOLD_CYC (HOLD_CYC),
  .CW       (CW),
  .ACT_HIGH (RST_ACT_HIGH)
) u_sup_rst_chk (
  .clk      (clk),
  .pwr_ok   (pwr_ok),
  .rst_out  (rst_out),
  .wdt_en   (wdt_en),
  .wdt_sel  (wdt_sel),
  .wdt_bite (wdt_bite),
  .cs_fall  (cs_fall),
  .wdt_cnt  (wdt_cnt)
);

// File: tb/test_sup_rst_gen.sv
`timescale 1ns/1ps
module test_sup_rst_gen;
  localparam int unsigned CLK_HZ = 1000;  // one cycle per millisecond
  localparam int unsigned HOLD   = 20;
  localparam int unsigned L_LONG = 50;
  localparam int unsigned L_MID  = 35;
  localparam int unsigned L_SHRT = 25;

  logic       clk = 1'b0;
  logic       pwr_ok = 1'b0;
  logic       cs_n = 1'b1;
  logic       wdt_en = 1'b1;
  logic [1:0] wdt_sel = 2'b00;
  logic       rst_lo;
  logic       rst_hi;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sup_rst_gen #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD), .WDT_LONG_MS(L_LONG),
                .WDT_MID_MS(L_MID), .WDT_SHORT_MS(L_SHRT), .RST_ACT_HIGH(1'b0))
  i_sup_rst_gen (.clk(clk), .pwr_ok(pwr_ok), .cs_n(cs_n), .wdt_en(wdt_en),
                 .wdt_sel(wdt_sel), .rst_out(rst_lo));

  sup_rst_gen #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD), .WDT_LONG_MS(L_LONG),
                .WDT_MID_MS(L_MID), .WDT_SHORT_MS(L_SHRT), .RST_ACT_HIGH(1'b1))
  i_sup_rst_gen_ah (.clk(clk), .pwr_ok(pwr_ok), .cs_n(cs_n), .wdt_en(wdt_en),
                    .wdt_sel(wdt_sel), .rst_out(rst_hi));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Checks that both variants show reset asserted (on=1) or released (on=0).
  task automatic chk(input string req, input string what, input bit on);
    n_vec++;
    if (rst_lo !== ~on || rst_hi !== on) begin
      n_fail++;
      $display("FAIL %s %s: rst_lo=%b rst_hi=%b expected %b/%b",
               req, what, rst_lo, rst_hi, ~on, on);
    end
  endtask

  task automatic power_up();
    pwr_ok = 1'b0;
    cs_n   = 1'b1;
    step(3);
    pwr_ok = 1'b1;
    step(HOLD + 2);
  endtask

  task automatic t_reset_state();
    step(3);
    chk("R1", "supply low at start", 1'b1);
    n_vec++;
    if (rst_lo !== 1'b0 || rst_hi !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 polarity: lo=%b hi=%b expected 0/1", rst_lo, rst_hi);
    end
  endtask

  task automatic t_powerup_r2();
    pwr_ok = 1'b1;
    step(HOLD + 1);
    chk("R2", "one edge before release", 1'b1);
    step(1);
    chk("R2", "released", 1'b0);
    n_vec++;
    if (rst_lo !== 1'b1 || rst_hi !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 released polarity: lo=%b hi=%b expected 1/0", rst_lo, rst_hi);
    end
  endtask

  task automatic t_dip_r3();
    pwr_ok = 1'b0;
    #1;
    chk("R1", "immediate assert on drop", 1'b1);
    step(3);
    pwr_ok = 1'b1;
    step(10);
    pwr_ok = 1'b0;
    #1;
    chk("R1", "drop inside hold", 1'b1);
    step(2);
    pwr_ok = 1'b1;
    step(HOLD + 1);
    chk("R3", "hold restarted in full", 1'b1);
    step(1);
    chk("R3", "released after full hold", 1'b0);
  endtask

  task automatic t_high_stuck_r5();
    wdt_en = 1'b1; wdt_sel = 2'b10;
    power_up();
    step(L_SHRT - 1);
    chk("R5", "cs high, before timeout", 1'b0);
    step(1);
    chk("R5", "cs high, timeout", 1'b1);
    step(HOLD - 1);
    chk("R8", "held after bite", 1'b1);
    step(1);
    chk("R8", "released after bite hold", 1'b0);
    step(L_SHRT - 1);
    chk("R8", "restart from zero, before", 1'b0);
    step(1);
    chk("R8", "restart from zero, timeout", 1'b1);
  endtask

  task automatic t_low_stuck_r4();
    wdt_en = 1'b1; wdt_sel = 2'b01;
    power_up();
    step(5);
    cs_n = 1'b0;
    step(10);
    cs_n = 1'b1;  // rising edge must not restart the count
    step(L_MID + 2 - 10);
    chk("R6", "rise ignored, before timeout", 1'b0);
    step(1);
    chk("R4", "timeout counted from falling edge", 1'b1);
  endtask

  task automatic t_kick_r6();
    wdt_en = 1'b1; wdt_sel = 2'b10;
    power_up();
    for (int i = 0; i < 8; i++) begin
      step(10);
      cs_n = 1'b0;
      step(10);
      cs_n = 1'b1;
      chk("R6", $sformatf("kicked pass %0d", i), 1'b0);
    end
  endtask

  task automatic t_disable_r7();
    wdt_en = 1'b0; wdt_sel = 2'b10;
    power_up();
    step(3 * L_LONG);
    chk("R7", "enable low", 1'b0);
    wdt_en = 1'b1; wdt_sel = 2'b11;
    step(3 * L_LONG);
    chk("R7", "select 11 off", 1'b0);
    wdt_sel = 2'b00;
    step(L_LONG - 1);
    chk("R7", "select 00, before long timeout", 1'b0);
    step(1);
    chk("R7", "select 00, long timeout", 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_powerup_r2();
    t_dip_r3();
    t_high_stuck_r5();
    t_low_stuck_r4();
    t_kick_r6();
    t_disable_r7();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule